// File: doc/BRIEF.md
# Core Module Control Register File

This block is the small register bank that sits beside a processor core and holds its board-level settings. Software reaches it through a word-addressed write port and a combinational read port. It keeps two clock-synthesizer setting words that software may change only after writing an unlock key. It also keeps a control word, a memory configuration word, an initialisation word and two banks of flag bits. Each flag bank has one address that sets bits and another that clears them, so software never has to read, modify and write a flag word.

The control word drives three things. Bit 0 lights a status LED. Bit 2 chooses the boot memory map: while it is clear, boot flash answers at address zero, and while it is set, the flash is unmapped so that RAM appears there instead. Writing bit 3 as one requests a system reset. That bit produces a one-cycle pulse and is never stored.

A free-running counter advances once per reference tick. A prescaler parameter sets the number of system clocks in one tick, chosen so that the counter runs at 24 MHz. Several read-only words return fixed identification and status values. The reset value of the memory configuration word carries a code for the installed memory size.

Top module: `cmod_ctrl_regs`

## Requirements
- R1: Word 0 reads 0x411A3001, word 4 reads 0x00100000, and word 1, words 32 to 35 and every word not named in R2 to R12 read zero. The write-only words 13 and 15 also read zero.
- R2: A write to word 5 stores only data bits 15:0. While the stored value is 0xA05F, word 5 reads 0x0001A05F. Otherwise it reads the stored value zero-extended.
- R3: Writes to word 2 and word 7 take effect only while word 5 holds 0xA05F. At any other time they leave the register unchanged.
- R4: After reset, word 2 reads 0x01000048, word 7 reads 0x0007FEFF, word 9 reads 0x00000112 and word 5 reads 0. Word 8 reads 0x00011122 ORed with a size code: 0x10 for MEM_MB of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 below 32.
- R5: A write to word 3 keeps data bits 0 and 2. Word 3 reads those two bits in place, and every other bit, bit 3 included, reads zero.
- R6: A write to word 3 with data bit 3 set raises rst_req for exactly the one cycle after the write edge. A write with bit 3 clear raises no pulse.
- R7: remap_ram follows stored control bit 2 and led follows stored control bit 0. Both are 0 during and after reset, and neither changes except through a write to word 3.
- R8: A write to word 12 ORs the data into the flag bank, and a write to word 13 clears each flag bit written as one. Word 12 reads the bank.
- R9: Words 14 and 15 set and clear a second, independent flag bank in the same way, and word 14 reads that bank.
- R10: Word 10 reads 0 in reset. After reset it advances by one every TICK_DIV clock cycles and wraps modulo 2^32.
- R11: Writes to read-only or unimplemented words, word 10 included, change no register and no output.
- R12: Words 8 and 9 store all 32 data bits on a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for one word |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| rst_req | output | 1 | One-cycle system reset request |
| remap_ram | output | 1 | 1 removes boot flash from address zero so RAM shows through |
| led | output | 1 | Status LED drive |

## Verification
The assertions take rst_n as the reset reference. Internally the block stays in reset for two further cycles after rst_n rises, so the stimulus issues no write until that release has settled. The assertions also assume that at most one write arrives per cycle and that the write address and data are stable around the clock edge. The bench drives every input at the falling edge and holds wr_en for exactly one rising edge per write. The reset-pulse properties are written so that back-to-back control writes would still satisfy them, but the stimulus always separates control writes by idle cycles so that each pulse can be observed on its own.

// File: rtl/cmod_pkg.sv
package cmod_pkg;

  localparam int unsigned WORD_W = 32;

  // word offsets whose position software depends on
  localparam int unsigned RG_ID      = 0;
  localparam int unsigned RG_OSC     = 2;
  localparam int unsigned RG_CTRL    = 3;
  localparam int unsigned RG_STAT    = 4;
  localparam int unsigned RG_KEY     = 5;
  localparam int unsigned RG_AUX     = 7;
  localparam int unsigned RG_MEMCFG  = 8;
  localparam int unsigned RG_INIT    = 9;
  localparam int unsigned RG_REFCNT  = 10;
  localparam int unsigned RG_FLG_SET = 12;  // bank b: set at 12+2b, clear at 13+2b

  localparam logic [WORD_W-1:0] ID_VALUE    = 32'h411A_3001;
  localparam logic [WORD_W-1:0] STAT_VALUE  = 32'h0010_0000;
  localparam logic [WORD_W-1:0] OSC_RESET   = 32'h0100_0048;
  localparam logic [WORD_W-1:0] AUX_RESET   = 32'h0007_FEFF;
  localparam logic [WORD_W-1:0] INIT_RESET  = 32'h0000_0112;
  localparam logic [WORD_W-1:0] MEMCFG_BASE = 32'h0001_1122;

  localparam int unsigned KEY_W = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;

  localparam int unsigned CTRL_LED   = 0;
  localparam int unsigned CTRL_REMAP = 2;
  localparam int unsigned CTRL_RESET = 3;

  function automatic logic [WORD_W-1:0] memcfg_reset(input int unsigned mb);
    logic [WORD_W-1:0] code;
    if (mb >= 256)      code = 32'h10;
    else if (mb >= 128) code = 32'h0C;
    else if (mb >= 64)  code = 32'h08;
    else if (mb >= 32)  code = 32'h04;
    else                code = 32'h00;
    return MEMCFG_BASE | code;
  endfunction

endpackage

// File: rtl/cmod_rst_sync.sv
module cmod_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/cmod_key_lock.sv
module cmod_key_lock #(
  parameter int unsigned KW = 16,
  parameter logic [KW-1:0] KEY = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [KW-1:0] wr_key,
  output logic [KW-1:0] key_q,
  output logic          open
);
  logic          key_en;
  logic [KW-1:0] key_d;

  always_comb begin
    key_en = wr_stb;
    key_d  = wr_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (key_en) key_q <= key_d;
  end

  assign open = (key_q == KEY);
endmodule

// File: rtl/cmod_flag_bank.sv
module cmod_flag_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] bits_q
);
  logic         bits_en;
  logic [W-1:0] bits_d;

  always_comb begin
    bits_en = set_stb | clr_stb;
    bits_d  = bits_q;
    if (set_stb)      bits_d = bits_q | wr_data;
    else if (clr_stb) bits_d = bits_q & ~wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (bits_en) bits_q <= bits_d;
  end
endmodule

// File: rtl/cmod_ref_counter.sv
module cmod_ref_counter #(
  parameter int unsigned W   = 32,
  parameter int unsigned DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count_q
);
  logic         tick;
  logic [W-1:0] count_d;

  if (DIV <= 1) begin : g_direct
    assign tick = 1'b1;
  end else begin : g_prescale
    localparam int unsigned PW = $clog2(DIV);
    logic [PW-1:0] ph_q, ph_d;
    logic          ph_wrap;

    always_comb begin
      ph_wrap = (ph_q == PW'(DIV - 1));
      ph_d    = ph_wrap ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= ph_d;
    end

    assign tick = ph_wrap;
  end

  always_comb count_d = count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (tick) count_q <= count_d;
  end
endmodule

// File: rtl/cmod_ctrl_regs.sv
module cmod_ctrl_regs
  import cmod_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned MEM_MB   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rst_req,
  output logic              remap_ram,
  output logic              led
);
  localparam logic [WORD_W-1:0] MEMCFG_RST = memcfg_reset(MEM_MB);
  localparam int unsigned       N_BANKS    = 2;

  logic srst_n;

  cmod_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // write decode
  logic wr_osc, wr_ctrl, wr_key, wr_aux, wr_mem, wr_init;

  always_comb begin
    wr_osc  = wr_en && (wr_addr == ADDR_W'(RG_OSC));
    wr_ctrl = wr_en && (wr_addr == ADDR_W'(RG_CTRL));
    wr_key  = wr_en && (wr_addr == ADDR_W'(RG_KEY));
    wr_aux  = wr_en && (wr_addr == ADDR_W'(RG_AUX));
    wr_mem  = wr_en && (wr_addr == ADDR_W'(RG_MEMCFG));
    wr_init = wr_en && (wr_addr == ADDR_W'(RG_INIT));
  end

  // unlock key for the oscillator words
  logic [KEY_W-1:0] key_q;
  logic             lock_open;

  cmod_key_lock #(.KW(KEY_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_stb (wr_key),
    .wr_key (wr_data[KEY_W-1:0]),
    .key_q  (key_q),
    .open   (lock_open)
  );

  // set/clear flag banks
  logic [N_BANKS-1:0][WORD_W-1:0] flag_q;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic set_s, clr_s;
    assign set_s = wr_en && (wr_addr == ADDR_W'(RG_FLG_SET + 2 * b));
    assign clr_s = wr_en && (wr_addr == ADDR_W'(RG_FLG_SET + 2 * b + 1));

    cmod_flag_bank #(.W(WORD_W)) u_bank (
      .clk     (clk),
      .rst_n   (srst_n),
      .set_stb (set_s),
      .clr_stb (clr_s),
      .wr_data (wr_data),
      .bits_q  (flag_q[b])
    );
  end

  // reference counter
  logic [WORD_W-1:0] ref_count;

  cmod_ref_counter #(.W(WORD_W), .DIV(TICK_DIV)) u_refcnt (
    .clk     (clk),
    .rst_n   (srst_n),
    .count_q (ref_count)
  );

  // plain storage words
  logic [WORD_W-1:0] osc_q, osc_d, aux_q, aux_d, mem_q, mem_d, init_q, init_d;
  logic              osc_en, aux_en, mem_en, init_en;
  logic              led_q, led_d, remap_q, remap_d, rreq_q, rreq_d;

  always_comb begin
    osc_en  = wr_osc & lock_open;
    aux_en  = wr_aux & lock_open;
    mem_en  = wr_mem;
    init_en = wr_init;
    osc_d   = wr_data;
    aux_d   = wr_data;
    mem_d   = wr_data;
    init_d  = wr_data;
    led_d   = wr_data[CTRL_LED];
    remap_d = wr_data[CTRL_REMAP];
    rreq_d  = wr_ctrl & wr_data[CTRL_RESET];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      osc_q   <= OSC_RESET;
      aux_q   <= AUX_RESET;
      mem_q   <= MEMCFG_RST;
      init_q  <= INIT_RESET;
      led_q   <= 1'b0;
      remap_q <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      if (osc_en)  osc_q  <= osc_d;
      if (aux_en)  aux_q  <= aux_d;
      if (mem_en)  mem_q  <= mem_d;
      if (init_en) init_q <= init_d;
      if (wr_ctrl) begin
        led_q   <= led_d;
        remap_q <= remap_d;
      end
      rreq_q <= rreq_d;
    end
  end

  assign rst_req   = rreq_q;
  assign remap_ram = remap_q;
  assign led       = led_q;

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(RG_ID):          rd_data = ID_VALUE;
      ADDR_W'(RG_OSC):         rd_data = osc_q;
      ADDR_W'(RG_CTRL): begin
        rd_data[CTRL_LED]   = led_q;
        rd_data[CTRL_REMAP] = remap_q;
      end
      ADDR_W'(RG_STAT):        rd_data = STAT_VALUE;
      ADDR_W'(RG_KEY):         rd_data = {15'b0, lock_open, key_q};
      ADDR_W'(RG_AUX):         rd_data = aux_q;
      ADDR_W'(RG_MEMCFG):      rd_data = mem_q;
      ADDR_W'(RG_INIT):        rd_data = init_q;
      ADDR_W'(RG_REFCNT):      rd_data = ref_count;
      ADDR_W'(RG_FLG_SET):     rd_data = flag_q[0];
      ADDR_W'(RG_FLG_SET + 2): rd_data = flag_q[1];
      default:                 rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cmod_ctrl_regs_chk.sv
module cmod_ctrl_regs_chk
  import cmod_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              rst_req,
  input logic              remap_ram,
  input logic              led,
  input logic [WORD_W-1:0] osc_q,
  input logic [WORD_W-1:0] aux_q,
  input logic              lock_open,
  input logic [WORD_W-1:0] flags_q,
  input logic [WORD_W-1:0] ref_q
);
  logic ctrl_wr, rst_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(RG_CTRL));
  assign rst_wr  = ctrl_wr && wr_data[CTRL_RESET];

  // R6
  rst_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rst_wr));

  // R6
  rst_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !rst_wr) |=> !rst_req);

  // R7
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ($stable(remap_ram) && $stable(led)));

  // R3
  osc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(RG_OSC) && !lock_open) |=> $stable(osc_q));

  // R3
  aux_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(RG_AUX) && !lock_open) |=> $stable(aux_q));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(RG_FLG_SET + 1)) |=> ((flags_q & $past(wr_data)) == '0));

  // R10
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q - $past(ref_q)) <= 32'd1);
endmodule

bind cmod_ctrl_regs cmod_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rst_req   (rst_req),
  .remap_ram (remap_ram),
  .led       (led),
  .osc_q     (osc_q),
  .aux_q     (aux_q),
  .lock_open (lock_open),
  .flags_q   (flag_q[0]),
  .ref_q     (ref_count)
);

// File: tb/cmod_ctrl_regs_bench.sv
module cmod_ctrl_regs_bench;
  localparam int AW  = 6;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic          rst_req, remap_ram, led;
  logic [31:0]   sm_rd;
  logic          sm_req, sm_map, sm_led;

  always #4 clk = ~clk;

  cmod_ctrl_regs #(.ADDR_W(AW), .TICK_DIV(DIV), .MEM_MB(128)) u_cmod_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req),
    .remap_ram(remap_ram), .led(led)
  );

  cmod_ctrl_regs #(.ADDR_W(AW), .TICK_DIV(DIV), .MEM_MB(16)) u_small (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_addr('0), .wr_data('0),
    .rd_addr(6'd8), .rd_data(sm_rd), .rst_req(sm_req),
    .remap_ram(sm_map), .led(sm_led)
  );

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [31:0] m_osc, m_aux, m_mem, m_init, m_flg, m_nvf;
  logic [15:0] m_key;
  logic        m_led, m_map;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      0:  return 32'h411A3001;
      2:  return m_osc;
      3:  return {29'b0, m_map, 1'b0, m_led};
      4:  return 32'h00100000;
      5:  return (m_key == 16'hA05F) ? {16'h0001, m_key} : {16'h0000, m_key};
      7:  return m_aux;
      8:  return m_mem;
      9:  return m_init;
      12: return m_flg;
      14: return m_nvf;
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd(input int a, output logic [31:0] v);
    rd_addr = AW'(a);
    #1;
    v = rd_data;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sweep(input string req);
    logic [31:0] v;
    for (int a = 0; a < 64; a++) begin
      if (a != 10) begin
        rd(a, v);
        chk(req, v, exp_rd(a));
      end
    end
  endtask

  function automatic bit writable(input int a);
    return (a == 2 || a == 3 || a == 5 || a == 7 || a == 8 || a == 9 ||
            (a >= 12 && a <= 15));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0, c1, lf, d;
    logic [31:0] keys [8];
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_init = 32'h112;
    m_mem = 32'h0001112E; m_key = '0; m_led = 0; m_map = 0; m_flg = '0; m_nvf = '0;
    repeat (3) @(negedge clk);

    // R10 / R7 while in reset
    rd(10, v); chk("R10 count in reset", v, 32'h0);
    chk("R7 remap in reset", {31'b0, remap_ram}, 32'h0);
    chk("R7 led in reset", {31'b0, led}, 32'h0);
    chk("R6 no request in reset", {31'b0, rst_req}, 32'h0);

    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 reset values, R1 constants and unimplemented words
    sweep("R4/R1 reset sweep");
    chk("R4 small memory config", sm_rd, 32'h00011122);

    // R11 writes to read-only and unimplemented words
    for (int a = 0; a < 64; a++)
      if (!writable(a)) wr(a, 32'hFFFF_FFFF);
    sweep("R11 after read-only writes");
    chk("R11 outputs untouched", {29'b0, rst_req, remap_ram, led}, 32'h0);

    // R2 / R3 lock key sweep
    keys = '{32'h12345678, 32'hFFFFA05F, 32'h0001A05E, 32'h0000A05E,
             32'h0000A05F, 32'h0000FFFF, 32'h5555A05F, 32'h00000000};
    for (int i = 0; i < 8; i++) begin
      wr(5, keys[i]); m_key = keys[i][15:0];
      rd(5, v); chk("R2 key readback", v, exp_rd(5));
      d = keys[i] ^ 32'h5A5A_5A5A ^ 32'(i);
      wr(2, d); if (m_key == 16'hA05F) m_osc = d;
      rd(2, v); chk("R3 osc gated", v, m_osc);
      wr(7, ~d); if (m_key == 16'hA05F) m_aux = ~d;
      rd(7, v); chk("R3 aux gated", v, m_aux);
    end

    // R5 / R6 / R7 control word sweep
    for (int i = 0; i < 32; i++) begin
      d = (i >= 16) ? (32'hFFFF_FFF0 | 32'(i & 15)) : 32'(i);
      wr(3, d);
      chk("R6 pulse after write", {31'b0, rst_req}, {31'b0, d[3]});
      m_led = d[0]; m_map = d[2];
      @(negedge clk);
      chk("R6 pulse one cycle", {31'b0, rst_req}, 32'h0);
      rd(3, v); chk("R5 control readback", v, exp_rd(3));
      chk("R7 remap output", {31'b0, remap_ram}, {31'b0, m_map});
      chk("R7 led output", {31'b0, led}, {31'b0, m_led});
    end

    // R8 / R9 flag banks, pseudo-random set and clear
    lf = 32'hACE1_1234;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      d  = lf ^ {lf[15:0], lf[31:16]};
      case ((i < 4) ? 2 * (i % 2) : int'(lf[3:2]))
        0: begin wr(12, d); m_flg = m_flg | d;  end
        1: begin wr(13, d); m_flg = m_flg & ~d; end
        2: begin wr(14, d); m_nvf = m_nvf | d;  end
        default: begin wr(15, d); m_nvf = m_nvf & ~d; end
      endcase
      rd(12, v); chk("R8 flag bank", v, m_flg);
      rd(14, v); chk("R9 nv flag bank", v, m_nvf);
    end
    rd(13, v); chk("R1 clear word reads zero", v, 32'h0);
    rd(15, v); chk("R1 nv clear word reads zero", v, 32'h0);

    // R12 memory config and init words
    wr(8, 32'hDEAD_BEEF); m_mem = 32'hDEAD_BEEF;
    wr(9, 32'h8000_0001); m_init = 32'h8000_0001;
    sweep("R12 full sweep");

    // R10 counter rate
    rd(10, c0);
    repeat (40) @(negedge clk);
    rd(10, c1);
    chk("R10 count advance", c1 - c0, 32'd40 / DIV);
    wr(10, 32'h0);
    rd(10, c0);
    repeat (DIV * 3) @(negedge clk);
    rd(10, c1);
    chk("R11 counter ignores writes", c1 - c0, 32'd3);

    finish_run();
  end
endmodule